// File: doc/BRIEF.md
# Phase-Detector Lock Qualifier

This block decides whether a phase-locked loop has settled. It watches the Up and Down pulses that a phase-frequency detector produces. Once per reference period it measures how long the two pulses disagree, in ticks of a fast sampling clock. The reference clock, Up and Down are all brought into the sampling-clock domain through a synchroniser. A reference period runs from one synchronised rising reference edge to the next.

Lock cannot be granted straight away. A qualification timer must first count a selectable number of reference periods. After that, the first period whose disagreement time falls under the selected window raises the lock flag. The flag is then sticky: the timer is frozen, and only a period whose disagreement reaches the window clears lock and restarts the timer from zero. A separate status output mirrors lock only while its visibility enable is set.

Top module: `pll_lock_qualifier`

## Requirements
- R1: While reset is asserted and immediately after it, `lock_o` and `status_o` are 0 and the qualification count is zero.
- R2: The measurement for a reference period is the number of sampling cycles in which synchronised Up and Down differ. Cycles in which both are high, or both are low, add nothing. The count saturates at its maximum.
- R3: The wait length is set by `qual_sel_i`: 2'b00 selects 16 periods, 2'b01 selects 2, 2'b10 selects 4 and 2'b11 selects 8. After reset or after an unlock, that many measurements must complete before one can grant lock, so the earliest grant comes at the next measurement.
- R4: Once the wait has expired and lock is low, a measurement below the window raises lock. A measurement at or above the window leaves lock low and does not restart the wait. Measurements taken during the wait do not affect the wait.
- R5: `win_sel_i` = 0 selects a window of SHORT_TICKS sampling cycles, and 1 selects LONG_TICKS cycles. A measurement equal to the window counts as too large.
- R6: While lock is high, a measurement below the window keeps it high. Changing `qual_sel_i`, `win_sel_i` or `stat_en_i` never clears lock by itself.
- R7: While lock is high, a measurement at or above the window clears lock and resets the qualification count to zero.
- R8: `status_o` equals `lock_o` while `stat_en_i` is 1 and reads 0 while it is 0.
- R9: Both select fields are sampled at each synchronised rising reference edge. The measurement that completes at that edge is judged with the newly sampled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, sampled as data |
| up_i | input | 1 | Up pulse from the phase-frequency detector |
| dn_i | input | 1 | Down pulse from the phase-frequency detector |
| qual_sel_i | input | 2 | Wait-length select (16/2/4/8 periods) |
| win_sel_i | input | 1 | Window select: 0 short, 1 long |
| stat_en_i | input | 1 | Status visibility enable |
| lock_o | output | 1 | Registered lock flag |
| status_o | output | 1 | Registered lock status, gated by the enable |

## Verification
The bench uses the default build: a 6-bit mismatch counter, a short window of 4 ticks and a long window of 8 ticks. It drives a reference period of 32 sampling cycles. With these small windows, both boundary pairs (3 against 4, and 7 against 8) fit inside half a reference period, so each side of each threshold is hit exactly. All four wait encodings are exercised, and the 2-period wait makes the restart after an unlock show up within three periods.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  localparam int QUAL_W = 5;

  typedef enum logic [1:0] {
    QSEL_16 = 2'b00,
    QSEL_2  = 2'b01,
    QSEL_4  = 2'b10,
    QSEL_8  = 2'b11
  } qual_sel_e;

  function automatic logic [QUAL_W-1:0] qual_periods(input qual_sel_e sel);
    case (sel)
      QSEL_2:  return QUAL_W'(2);
      QSEL_4:  return QUAL_W'(4);
      QSEL_8:  return QUAL_W'(8);
      default: return QUAL_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[g] <= '0;
      end else if (g == 0) begin
        stage[g] <= d;
      end else begin
        stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lockq_mismatch.sv
module lockq_mismatch #(
  parameter int MIS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_s,
  input  logic             dn_s,
  input  logic             ref_edge,
  output logic [MIS_W-1:0] meas_cnt,
  output logic             meas_vld
);
  localparam logic [MIS_W-1:0] CNT_MAX = '1;

  logic [MIS_W-1:0] run_cnt;
  logic [MIS_W-1:0] run_next;
  logic             differ;

  assign differ = up_s ^ dn_s;

  always_comb begin
    run_next = run_cnt;
    if (differ && (run_cnt != CNT_MAX)) begin
      run_next = run_cnt + MIS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      meas_cnt <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= ref_edge;
      if (ref_edge) begin
        meas_cnt <= run_next;
        run_cnt  <= '0;
      end else begin
        run_cnt  <= run_next;
      end
    end
  end
endmodule

// File: rtl/lockq_qual_timer.sv
module lockq_qual_timer #(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold,
  input  logic          clear,
  input  logic [QW-1:0] target,
  output logic [QW-1:0] count,
  output logic          done
);
  assign done = (count >= target);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (tick && !hold && !done) begin
      count <= count + QW'(1);
    end
  end
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
  import lockq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIS_W       = 6,
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk_i,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic [1:0] qual_sel_i,
  input  logic       win_sel_i,
  input  logic       stat_en_i,
  output logic       lock_o,
  output logic       status_o
);
  localparam logic [MIS_W-1:0] SHORT_THR = MIS_W'(SHORT_TICKS);
  localparam logic [MIS_W-1:0] LONG_THR  = MIS_W'(LONG_TICKS);

  logic [2:0]        raw_vec;
  logic [2:0]        sync_vec;
  logic              ref_s, up_s, dn_s;
  logic              ref_d;
  logic              ref_edge;
  qual_sel_e         qual_sel_q;
  logic              win_sel_q;
  logic [MIS_W-1:0]  win_thr;
  logic [QUAL_W-1:0] qual_target;
  logic [MIS_W-1:0]  meas_cnt;
  logic              meas_vld;
  logic [QUAL_W-1:0] qual_cnt;
  logic              qual_done;
  logic              lock_q;
  logic              status_q;
  logic              grant_evt;
  logic              unlock_evt;

  assign raw_vec = {ref_clk_i, up_i, dn_i};

  lockq_sync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_vec),
    .q  (sync_vec)
  );

  assign {ref_s, up_s, dn_s} = sync_vec;
  assign ref_edge = ref_s & ~ref_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d      <= 1'b0;
      qual_sel_q <= QSEL_16;
      win_sel_q  <= 1'b0;
    end else begin
      ref_d <= ref_s;
      if (ref_edge) begin
        qual_sel_q <= qual_sel_e'(qual_sel_i);
        win_sel_q  <= win_sel_i;
      end
    end
  end

  assign win_thr     = win_sel_q ? LONG_THR : SHORT_THR;
  assign qual_target = qual_periods(qual_sel_q);

  lockq_mismatch #(
    .MIS_W(MIS_W)
  ) u_mismatch (
    .clk     (clk),
    .rst     (rst),
    .up_s    (up_s),
    .dn_s    (dn_s),
    .ref_edge(ref_edge),
    .meas_cnt(meas_cnt),
    .meas_vld(meas_vld)
  );

  assign grant_evt  = meas_vld && !lock_q && qual_done && (meas_cnt < win_thr);
  assign unlock_evt = meas_vld &&  lock_q && (meas_cnt >= win_thr);

  lockq_qual_timer #(
    .QW(QUAL_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .tick  (meas_vld),
    .hold  (lock_q),
    .clear (unlock_evt),
    .target(qual_target),
    .count (qual_cnt),
    .done  (qual_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (grant_evt) begin
        lock_q <= 1'b1;
      end else if (unlock_evt) begin
        lock_q <= 1'b0;
      end
      status_q <= stat_en_i & lock_q;
    end
  end

  assign lock_o   = lock_q;
  assign status_o = status_q;
endmodule

// File: rtl/lockq_checker.sv
module lockq_checker #(
  parameter int MW = 6,
  parameter int QW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          lock_o,
  input logic          status_o,
  input logic          stat_en,
  input logic          meas_vld,
  input logic [MW-1:0] meas_cnt,
  input logic [MW-1:0] win_thr,
  input logic          qual_done,
  input logic [QW-1:0] qual_cnt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!lock_o && !status_o && (qual_cnt == '0)));

  assert_lock_after_wait_R3: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> qual_done);

  assert_lock_moves_on_result_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_o != $past(lock_o)) |-> $past(meas_vld));

  assert_unlock_on_large_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_o && meas_vld && (meas_cnt >= win_thr)) |=> !lock_o);

  assert_timer_restart_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> (qual_cnt == '0));

  assert_status_hidden_R8: assert property (@(posedge clk) disable iff (rst)
    !stat_en |=> !status_o);

  assert_status_follows_R8: assert property (@(posedge clk) disable iff (rst)
    status_o |-> $past(lock_o));
endmodule

bind pll_lock_qualifier lockq_checker #(
  .MW(MIS_W),
  .QW(lockq_pkg::QUAL_W)
) u_lockq_chk (
  .clk      (clk),
  .rst      (rst),
  .lock_o   (lock_o),
  .status_o (status_o),
  .stat_en  (stat_en_i),
  .meas_vld (meas_vld),
  .meas_cnt (meas_cnt),
  .win_thr  (win_thr),
  .qual_done(qual_done),
  .qual_cnt (qual_cnt)
);

// File: tb/pll_lock_qualifier_bench.sv
`timescale 1ns/1ps
module pll_lock_qualifier_bench;
  localparam int PER   = 32;
  localparam int SHORT = 4;
  localparam int LONG  = 8;
  localparam int PSTART = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic       up = 1'b0;
  logic       dn = 1'b0;
  logic [1:0] qual_sel = 2'b00;
  logic       win_sel = 1'b0;
  logic       stat_en = 1'b1;
  logic       lock_o;
  logic       status_o;

  always #4 clk = ~clk;

  pll_lock_qualifier #(
    .SHORT_TICKS(SHORT),
    .LONG_TICKS (LONG)
  ) u_pll_lock_qualifier (
    .clk       (clk),
    .rst       (rst),
    .ref_clk_i (ref_clk),
    .up_i      (up),
    .dn_i      (dn),
    .qual_sel_i(qual_sel),
    .win_sel_i (win_sel),
    .stat_en_i (stat_en),
    .lock_o    (lock_o),
    .status_o  (status_o)
  );

  typedef struct {
    bit    lock;
    bit    stat;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   sample_req = 1'b0;
  bit   finished = 1'b0;

  // reference model state
  int   m_q = 0;
  bit   m_lock = 1'b0;
  int   prev_up = 0;
  int   prev_dn = 0;
  logic [1:0] cur_qual = 2'b00;
  logic       cur_win = 1'b0;
  logic       cur_stat = 1'b1;

  function automatic int wait_len(input logic [1:0] s);
    case (s)
      2'b01:   return 2;
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 16;
    endcase
  endfunction

  task automatic model_step(input int m);
    int n;
    int thr;
    n   = wait_len(cur_qual);
    thr = cur_win ? LONG : SHORT;
    if (!m_lock) begin
      if (m_q >= n && m < thr) m_lock = 1'b1;
      else if (m_q < n) m_q++;
    end else if (m >= thr) begin
      m_lock = 1'b0;
      m_q    = 0;
    end
  endtask

  // driver: one reference period, pushes the expected state after its edge
  task automatic run_period(input int up_len, input int dn_len, input string req);
    int   m;
    exp_t e;
    m = (prev_up > prev_dn) ? prev_up - prev_dn : prev_dn - prev_up;
    model_step(m);
    e.lock = m_lock;
    e.stat = m_lock & cur_stat;
    e.req  = req;
    exp_q.push_back(e);
    prev_up = up_len;
    prev_dn = dn_len;
    for (int c = 0; c < PER; c++) begin
      @(posedge clk); #1;
      ref_clk = (c < PER/2);
      if (c == 0) begin
        qual_sel = cur_qual;
        win_sel  = cur_win;
        stat_en  = cur_stat;
      end
      up = (c >= PSTART) && (c < PSTART + up_len);
      dn = (c >= PSTART) && (c < PSTART + dn_len);
      sample_req = (c == 8);
    end
    sample_req = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (sample_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: no expected item (lock=%0b status=%0b)", lock_o, status_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (lock_o !== e.lock || status_o !== e.stat) begin
          failures++;
          $display("FAIL %s: lock=%0b status=%0b expected lock=%0b status=%0b at %0t",
                   e.req, lock_o, status_o, e.lock, e.stat, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (lock_o !== 1'b0 || status_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: lock=%0b status=%0b expected 0 0", lock_o, status_o);
    end

    // R3/R4: default 16-period wait; mismatches during the wait are ignored
    for (int j = 1; j <= 17; j++) begin
      run_period((j >= 2 && j <= 9) ? 7 : 0, 0, "R3");
    end
    run_period(2, 0, "R8");
    run_period(3, 0, "R6");
    cur_stat = 1'b0;
    run_period(0, 3, "R8");          // status hidden
    cur_stat = 1'b1;
    run_period(9, 9, "R6");          // dn-leading mismatch of 3 judged here
    run_period(0, 0, "R2");          // fully overlapping pulses count zero
    cur_win = 1'b1;
    run_period(7, 0, "R9");          // window change while locked
    run_period(0, 0, "R5");          // 7 below long window
    run_period(8, 0, "R6");
    run_period(0, 0, "R7");          // 8 reaches long window: unlock
    cur_qual = 2'b01;
    run_period(0, 0, "R7");
    run_period(0, 0, "R7");          // wait restarted from zero
    run_period(0, 0, "R3");          // 2-period wait done: lock
    cur_win = 1'b0;
    run_period(4, 0, "R5");
    run_period(0, 0, "R5");          // 4 reaches short window: unlock
    cur_qual = 2'b10;
    run_period(0, 0, "R3");
    run_period(0, 0, "R3");
    run_period(0, 0, "R3");
    run_period(5, 0, "R3");
    run_period(0, 0, "R4");          // wait done, 5 too large: no lock
    run_period(6, 0, "R4");          // next good result locks
    run_period(0, 0, "R7");          // 6 unlocks
    cur_qual = 2'b11;
    for (int j = 1; j <= 9; j++) begin
      run_period(0, 0, "R3");
    end

    finished = 1'b1;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule